// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from local peripherals into a source register. A software-programmed enable mask gates that register, and the block drives one combined interrupt line to the processor. Software reaches the block through a small 16-bit register port with two locations. One location is a vector register that reports the lowest-numbered request which is both pending and enabled. The other holds the enable mask, which software can read and write.

A handler reads the vector location to learn which enabled request to service. It services that device, which lowers the device's request line, and that in turn clears the matching source bit. No acknowledge write is needed. Software changes the enable mask to admit or hold off individual sources, and the combined output follows the new mask in the same clock edge that stores it.

Top module: `irqc_local_bus`

## Requirements
- R1: Each source bit copies its request input at every rising clock edge: it is 1 while the input is high and returns to 0 once the input is low.
- R2: The combined output `irq_out` is 1 exactly when (source AND mask) is nonzero. It is registered, so it reflects a request change one clock after the change is presented.
- R3: A read at offset 0x000 returns (n+1)*4, where n is the lowest-numbered bit set in (source AND mask). It returns 0 when that AND is zero. For example, bit 4 gives 20 and bit 15 gives 64.
- R4: Offset 0x002 holds the 16-bit enable mask, where bit i enables request i. A write there stores the written data, a read there returns it, and `irq_out` reflects the new mask at the same edge that stores it.
- R5: A synchronous active-high reset sets the mask to 0x0010, clears the source register and clears `irq_out`.
- R6: Only even offsets 0x000 and 0x002 are defined. Reads at any other offset, including odd ones, return 0, and writes to them change neither the mask nor the output.
- R7: Reading the vector changes neither the source register nor the mask, so repeated vector reads return the same value.
- R8: Read data is registered. `reg_rdata` carries the value in the cycle after the edge that samples `reg_rd`, and it is 0 in any cycle that follows an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Level request lines, synchronous to clk |
| reg_addr | input | 12 | Byte offset of register access |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined masked interrupt level |

## Verification
The assertions take for granted that the request lines are already synchronous to the block clock. They also assume that read and write strobes are never raised in the same cycle, because the checks relating the mask to the port address rely on it. The stimulus changes requests and strobes only just after a rising edge, issues each access as a single-cycle strobe with one direction at a time, and samples the outputs at the falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned N_SRC    = 16;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned ADDR_W   = 12;
    localparam logic [DATA_W-1:0] MASK_RST = 16'h0010;

    localparam logic [ADDR_W-1:0] OFS_VECTOR = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h002;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_VECTOR = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } reg_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        if (a == OFS_VECTOR)    return SEL_VECTOR;
        else if (a == OFS_MASK) return SEL_MASK;
        else                    return SEL_NONE;
    endfunction
endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] src_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) src_q[i] <= 1'b0;
            else     src_q[i] <= req[i];
        end
    end

    AST_SRC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (src_q == $past(req))); // R1
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_d,
    output logic [W-1:0] mask_q
);
    always_comb mask_d = wr_en ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= RST_VAL;
        else     mask_q <= mask_d;
    end

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q)); // R6
    AST_RESET_MASK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == RST_VAL)); // R5
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int unsigned N = 16,
    parameter int unsigned W = 16
) (
    input  logic [N-1:0] pend,
    output logic [W-1:0] code
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;
    logic             any;

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
        code = any ? (W'(idx) + W'(1)) << 2 : '0;
    end

    always_comb begin
        if (pend == '0) AST_ZERO_CODE: assert (code == '0); // R3
        else            AST_CODE_ALIGN: assert (code[1:0] == 2'b00 && code != '0); // R3
    end
endmodule

// File: rtl/irqc_local_bus.sv
module irqc_local_bus
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = N_SRC,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NSRC-1:0] irq_req,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    reg_cmd_t          cmd;
    logic [NSRC-1:0]   src_q;
    logic [DW-1:0]     mask_d, mask_q;
    logic [DW-1:0]     vec_code;
    logic [DW-1:0]     rd_val;
    logic [NSRC-1:0]   pend;

    always_comb begin
        cmd.rd    = reg_rd;
        cmd.wr    = reg_wr;
        cmd.sel   = decode_offset(reg_addr);
        cmd.wdata = reg_wdata;
    end

    irqc_src_latch #(.N(NSRC)) u_src (
        .clk(clk), .rst(rst), .req(irq_req), .src_q(src_q)
    );

    irqc_mask_reg #(.W(DW), .RST_VAL(MASK_RST)) u_mask (
        .clk(clk), .rst(rst),
        .wr_en(cmd.wr && cmd.sel == SEL_MASK),
        .wdata(cmd.wdata), .mask_d(mask_d), .mask_q(mask_q)
    );

    always_comb pend = src_q & mask_q[NSRC-1:0];

    irqc_prio_enc #(.N(NSRC), .W(DW)) u_enc (
        .pend(pend), .code(vec_code)
    );

    always_comb begin
        unique case (cmd.sel)
            SEL_VECTOR: rd_val = vec_code;
            SEL_MASK:   rd_val = mask_q;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq_out   <= 1'b0;
        end else begin
            reg_rdata <= cmd.rd ? rd_val : '0;
            irq_out   <= |(irq_req & mask_d[NSRC-1:0]);
        end
    end

    AST_OUT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(src_q & mask_q[NSRC-1:0])); // R2
    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> (reg_rdata == '0)); // R8
    AST_UNDEF_READ: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != OFS_VECTOR && reg_addr != OFS_MASK) |=> (reg_rdata == '0)); // R6
    AST_VEC_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == OFS_VECTOR) |=> $stable(mask_q)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (src_q == '0 && !irq_out)); // R5
endmodule

// File: tb/sim_irqc_local_bus.sv
module sim_irqc_local_bus;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_req = '0;
    logic [11:0] reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    logic [15:0] mdl_mask;

    always #2.5 clk = ~clk;

    irqc_local_bus u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input logic [15:0] p);
        for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
        return 16'h0;
    endfunction

    task automatic reg_read(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
        if (a == 12'h002) mdl_mask = d;
    endtask

    task automatic set_req(input logic [15:0] r);
        irq_req = r;
        tick();
        @(negedge clk);
        chk("R2", {15'b0, irq_out}, {15'b0, |(r & mdl_mask)});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        chk("R5 out", {15'b0, irq_out}, 16'h0);
        reg_read(12'h002, d); chk("R5 mask", d, 16'h0010);
        reg_read(12'h000, d); chk("R5 vec", d, 16'h0);
    endtask

    task automatic t_level();
        logic [15:0] d;
        set_req(16'h0010);
        reg_read(12'h000, d); chk("R1/R3 bit4", d, 16'd20);
        set_req(16'h0000);
        reg_read(12'h000, d); chk("R1 drop", d, 16'h0);
        set_req(16'h0001);
        reg_read(12'h000, d); chk("R3 masked", d, 16'h0);
    endtask

    task automatic t_mask();
        logic [15:0] d;
        reg_write(12'h002, 16'hFFFF);
        @(negedge clk);
        chk("R4 out on write", {15'b0, irq_out}, 16'h1);
        reg_read(12'h002, d); chk("R4 readback", d, 16'hFFFF);
        reg_read(12'h000, d); chk("R3 bit0", d, 16'd4);
        set_req(16'h8100);
        reg_read(12'h000, d); chk("R3 lowest", d, exp_vec(16'h8100));
        set_req(16'h8000);
        reg_read(12'h000, d); chk("R3 bit15", d, 16'd64);
        reg_write(12'h002, 16'h7FFF);
        @(negedge clk);
        chk("R4 drop on write", {15'b0, irq_out}, 16'h0);
        reg_write(12'h002, 16'hA5A5);
        set_req(16'h5A5B);
        reg_read(12'h000, d); chk("R3 mixed", d, exp_vec(16'h5A5B & 16'hA5A5));
    endtask

    task automatic t_undef();
        logic [15:0] d;
        reg_write(12'h004, 16'h0000);
        reg_write(12'h003, 16'h0000);
        reg_write(12'h001, 16'h0000);
        @(negedge clk);
        chk("R6 out kept", {15'b0, irq_out}, 16'h1);
        reg_read(12'h002, d); chk("R6 mask kept", d, 16'hA5A5);
        reg_read(12'h004, d); chk("R6 read 004", d, 16'h0);
        reg_read(12'h001, d); chk("R6 read odd", d, 16'h0);
        reg_read(12'hFFE, d); chk("R6 read FFE", d, 16'h0);
    endtask

    task automatic t_noside();
        logic [15:0] d1, d2, d3;
        reg_read(12'h000, d1);
        reg_read(12'h000, d2);
        chk("R7 repeat", d2, d1);
        reg_read(12'h002, d3); chk("R7 mask", d3, 16'hA5A5);
        tick();
        @(negedge clk);
        chk("R8 idle zero", reg_rdata, 16'h0);
    endtask

    initial begin
        mdl_mask = 16'h0010;
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_level();
        t_mask();
        t_undef();
        t_noside();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule